// File: doc/BRIEF.md
# Daisy-Chain Interrupt Priority Unit

This block decides which of its port channels may interrupt the processor and where it sits in a daisy chain of interrupting peripherals. Each channel presents an enable, a pending request and an 8-bit vector. The unit combines these with the chain enable arriving from upstream (`iei`). It then drives the processor interrupt request and the chain enable passed on to lower-priority devices (`ieo`).

During an interrupt acknowledge, the unit scans its channels in fixed priority order, with channel 0 the highest. The first enabled pending channel has its request cleared through a one-cycle pulse and is marked in service. Its vector appears on the output in the same cycle. A channel in service holds `ieo` low, which blocks everything downstream. It stays in service until a return-from-interrupt notification arrives. That notification releases the highest-priority channel in service. An acknowledge or notification that this unit does not consume is passed downstream on a forward output. Decoding the return opcode from the bus is done elsewhere.

Top module: `dcip_top`

## Requirements
- R1: After reset, or while reset is held, no channel is in service: `ieo` equals `iei` and `int_req` is low whenever no enabled request is pending.
- R2: `int_req` is high exactly when `iei` is high, no channel is in service, and at least one channel has both its `ch_en` bit and its `ch_req` bit set. A request whose enable bit is clear is not counted.
- R3: `ieo` is high exactly when `iei` is high, no channel is in service, and no channel has an enabled pending request.
- R4: When `ack` is high, the scan runs from index 0 (channel A) upward. If it reaches an enabled pending channel before any in-service channel, that channel wins. In the same cycle its bit in `req_clr` pulses, `vec_valid` is high and `vec_out` carries its vector (channel i uses bits [8i+7:8i] of `ch_vec`). From the next cycle on, the channel is in service.
- R5: If the acknowledge scan meets an in-service channel first, the acknowledge is invalid. In that cycle `vec_valid`, `req_clr` and `ack_fwd` all stay low, and the in-service state does not change.
- R6: If `ack` is high, no channel is in service and no enabled request is pending, `ack_fwd` is high in that cycle and `vec_valid` is low.
- R7: When `reti` is high, the lowest-index in-service channel leaves service on the next clock and `reti_fwd` stays low.
- R8: When `reti` is high and no channel is in service, `reti_fwd` is high in that cycle and the state does not change.
- R9: When `ack` and `reti` arrive in the same cycle, both are judged against the present in-service state. The release and the new grant both take effect on the next clock.
- R10: `vec_out` is all zeros whenever `vec_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iei | input | 1 | Chain enable from the upstream device |
| ch_en | input | NCH | Per-channel interrupt enable |
| ch_req | input | NCH | Per-channel pending request |
| ch_vec | input | NCH*VW | Per-channel vectors, channel i in bits [VW*i+VW-1:VW*i] |
| ack | input | 1 | Interrupt acknowledge, one-cycle pulse |
| reti | input | 1 | Return-from-interrupt notification, one-cycle pulse |
| int_req | output | 1 | Interrupt request to the processor |
| ieo | output | 1 | Chain enable to the downstream device |
| vec_out | output | VW | Vector of the granted channel |
| vec_valid | output | 1 | This unit claimed the current acknowledge |
| req_clr | output | NCH | One-cycle pulse clearing the granted channel's request |
| ack_fwd | output | 1 | Acknowledge passed downstream |
| reti_fwd | output | 1 | Return notification passed downstream |

## Verification
The hardest situations to reach from the ports involve a lower-priority channel in service while a higher-priority one raises a request. In one case that request must win a later acknowledge and leave both channels in service. In the other, the two in-service channels must be released one at a time in priority order. The stimulus table builds these states step by step: it grants channel 1 first and then raises channel 0. A later row releases one channel and grants another in the same cycle. Two shorter sequences cover the other cases: an acknowledge that meets the in-service channel first, and a reset applied while a channel is in service.

// File: rtl/dcip_pkg.sv
package dcip_pkg;

    // Outcome of the acknowledge scan for one cycle.
    typedef enum logic [1:0] {
        SCAN_IDLE    = 2'd0,
        SCAN_CLAIM   = 2'd1,
        SCAN_BLOCKED = 2'd2,
        SCAN_PASS    = 2'd3
    } scan_out_e;

endpackage

// File: rtl/dcip_ack_scan.sv
module dcip_ack_scan
    import dcip_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic           ack,
    input  logic [NCH-1:0] svc,
    input  logic [NCH-1:0] pend,
    output logic [NCH-1:0] grant,
    output scan_out_e      outcome
);

    // stop_pre[i]: some channel below index i already stops the scan
    logic [NCH:0]   stop_pre;
    logic [NCH-1:0] hit_svc;

    assign stop_pre[0] = 1'b0;

    for (genvar i = 0; i < NCH; i++) begin : g_chain
        assign stop_pre[i+1] = stop_pre[i] | svc[i] | pend[i];
        assign hit_svc[i]    = svc[i] & ~stop_pre[i];
        assign grant[i]      = ack & pend[i] & ~svc[i] & ~stop_pre[i];
    end

    always_comb begin
        if (!ack)
            outcome = SCAN_IDLE;
        else if (|hit_svc)
            outcome = SCAN_BLOCKED;
        else if (|grant)
            outcome = SCAN_CLAIM;
        else
            outcome = SCAN_PASS;
    end

endmodule

// File: rtl/dcip_reti_scan.sv
module dcip_reti_scan #(
    parameter int NCH = 2
) (
    input  logic           reti,
    input  logic [NCH-1:0] svc,
    output logic [NCH-1:0] release_oh,
    output logic           fwd
);

    logic [NCH:0] seen;

    assign seen[0] = 1'b0;

    for (genvar i = 0; i < NCH; i++) begin : g_first
        assign seen[i+1]     = seen[i] | svc[i];
        assign release_oh[i] = reti & svc[i] & ~seen[i];
    end

    assign fwd = reti & ~seen[NCH];

endmodule

// File: rtl/dcip_vec_mux.sv
module dcip_vec_mux #(
    parameter int NCH = 2,
    parameter int VW  = 8
) (
    input  logic [NCH-1:0]    sel_oh,
    input  logic [NCH*VW-1:0] vecs,
    output logic [VW-1:0]     vec
);

    always_comb begin
        vec = '0;
        for (int i = 0; i < NCH; i++) begin
            vec = vec | (vecs[i*VW +: VW] & {VW{sel_oh[i]}});
        end
    end

endmodule

// File: rtl/dcip_top.sv
module dcip_top
    import dcip_pkg::*;
#(
    parameter int NCH = 2,
    parameter int VW  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iei,
    input  logic [NCH-1:0]    ch_en,
    input  logic [NCH-1:0]    ch_req,
    input  logic [NCH*VW-1:0] ch_vec,
    input  logic              ack,
    input  logic              reti,
    output logic              int_req,
    output logic              ieo,
    output logic [VW-1:0]     vec_out,
    output logic              vec_valid,
    output logic [NCH-1:0]    req_clr,
    output logic              ack_fwd,
    output logic              reti_fwd
);

    typedef struct packed {
        logic [NCH-1:0] svc;
    } state_t;

    state_t state_q, state_d;

    logic [NCH-1:0] pend;
    logic [NCH-1:0] grant;
    logic [NCH-1:0] release_oh;
    scan_out_e      outcome;
    logic           any_svc;
    logic           any_pend;

    assign pend     = ch_en & ch_req;
    assign any_svc  = |state_q.svc;
    assign any_pend = |pend;

    dcip_ack_scan #(.NCH(NCH)) u_ack (
        .ack     (ack),
        .svc     (state_q.svc),
        .pend    (pend),
        .grant   (grant),
        .outcome (outcome)
    );

    dcip_reti_scan #(.NCH(NCH)) u_reti (
        .reti       (reti),
        .svc        (state_q.svc),
        .release_oh (release_oh),
        .fwd        (reti_fwd)
    );

    dcip_vec_mux #(.NCH(NCH), .VW(VW)) u_vmux (
        .sel_oh (grant),
        .vecs   (ch_vec),
        .vec    (vec_out)
    );

    assign int_req   = iei & ~any_svc & any_pend;
    assign ieo       = iei & ~any_svc & ~any_pend;
    assign vec_valid = (outcome == SCAN_CLAIM);
    assign ack_fwd   = (outcome == SCAN_PASS);
    assign req_clr   = grant;

    always_comb begin
        state_d     = state_q;
        state_d.svc = (state_q.svc & ~release_oh) | grant;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    AST_INT_NEEDS_IEI: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> iei);  // R2
    AST_IEO_INT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ieo && int_req));  // R3
    AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_clr));  // R4
    AST_CLAIM_SETS_SVC: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> (state_q.svc != '0));  // R4
    AST_BLOCKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !reti && any_svc && !vec_valid) |=> $stable(state_q.svc));  // R5
    AST_FWD_NOT_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_fwd && vec_valid));  // R6
    AST_RETI_FWD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        reti_fwd |-> (state_q.svc == '0));  // R8
    AST_VEC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_valid |-> (vec_out == '0));  // R10

endmodule

// File: tb/dcip_top_tb.sv
module dcip_top_tb;

    localparam int NCH = 2;
    localparam int VW  = 8;
    localparam int NROW = 24;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              iei;
    logic [NCH-1:0]    ch_en;
    logic [NCH-1:0]    ch_req;
    logic [NCH*VW-1:0] ch_vec;
    logic              ack;
    logic              reti;
    logic              int_req;
    logic              ieo;
    logic [VW-1:0]     vec_out;
    logic              vec_valid;
    logic [NCH-1:0]    req_clr;
    logic              ack_fwd;
    logic              reti_fwd;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    dcip_top #(.NCH(NCH), .VW(VW)) u_dut (
        .clk(clk), .rst_n(rst_n), .iei(iei), .ch_en(ch_en), .ch_req(ch_req),
        .ch_vec(ch_vec), .ack(ack), .reti(reti), .int_req(int_req), .ieo(ieo),
        .vec_out(vec_out), .vec_valid(vec_valid), .req_clr(req_clr),
        .ack_fwd(ack_fwd), .reti_fwd(reti_fwd)
    );

    // stimulus: iei en[1:0] req[1:0] ack reti
    // expected: int ieo valid vec[7:0] clr[1:0] ack_fwd reti_fwd
    // ch0 vector 8'hA2, ch1 vector 8'hB4
    localparam logic [21:0] TBL [NROW] = '{
        22'b1_00_00_0_0_0_1_0_00000000_00_0_0, // 0  R1 idle
        22'b1_11_00_0_0_0_1_0_00000000_00_0_0, // 1  R3 enabled, nothing pending
        22'b1_01_10_0_0_0_1_0_00000000_00_0_0, // 2  R2 request without enable
        22'b1_11_10_0_0_1_0_0_00000000_00_0_0, // 3  R2 R3 pending
        22'b0_11_10_0_0_0_0_0_00000000_00_0_0, // 4  R2 R3 iei low
        22'b1_11_11_0_0_1_0_0_00000000_00_0_0, // 5  R2 both pending
        22'b1_11_11_1_0_1_0_1_10100010_01_0_0, // 6  R4 ch0 wins
        22'b1_11_10_0_0_0_0_0_00000000_00_0_0, // 7  R3 in service blocks
        22'b1_11_10_1_0_0_0_0_00000000_00_0_0, // 8  R5 invalid ack
        22'b1_11_10_0_1_0_0_0_00000000_00_0_0, // 9  R7 release ch0
        22'b1_11_10_0_0_1_0_0_00000000_00_0_0, // 10 R7 released
        22'b1_11_10_1_0_1_0_1_10110100_10_0_0, // 11 R4 ch1 claims
        22'b1_11_11_1_0_0_0_1_10100010_01_0_0, // 12 R4 ch0 ahead of in-service ch1
        22'b1_11_00_0_1_0_0_0_00000000_00_0_0, // 13 R7 release ch0 first
        22'b1_11_00_0_1_0_0_0_00000000_00_0_0, // 14 R7 release ch1
        22'b1_11_00_0_1_0_1_0_00000000_00_0_1, // 15 R8 forward reti
        22'b1_11_00_1_0_0_1_0_00000000_00_1_0, // 16 R6 forward ack
        22'b1_11_01_1_0_1_0_1_10100010_01_0_0, // 17 R4 ch0 claims
        22'b1_11_10_0_1_0_0_0_00000000_00_0_0, // 18 R7 release ch0
        22'b1_11_10_1_0_1_0_1_10110100_10_0_0, // 19 R4 ch1 claims
        22'b1_11_01_1_1_0_0_1_10100010_01_0_0, // 20 R9 grant ch0, release ch1
        22'b1_11_00_0_0_0_0_0_00000000_00_0_0, // 21 R9 ch0 still in service
        22'b1_11_00_0_1_0_0_0_00000000_00_0_0, // 22 R7 release ch0
        22'b1_11_00_0_0_0_1_0_00000000_00_0_0  // 23 R3 chain open again
    };

    function automatic logic [14:0] observed();
        return {int_req, ieo, vec_valid, vec_out, req_clr, ack_fwd, reti_fwd};
    endfunction

    task automatic check(input string tag, input logic [14:0] act, input logic [14:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [6:0] s);
        {iei, ch_en, ch_req, ack, reti} = s;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        ch_vec = {8'hB4, 8'hA2};
        rst_n  = 1'b0;
        drive(7'b1_00_00_0_0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        check("R1 ieo follows iei high in reset", {14'b0, ieo}, 15'd1);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check("R1 idle after reset", observed(), 15'b0_1_0_00000000_00_0_0);

        for (int r = 0; r < NROW; r++) begin
            @(negedge clk);
            drive(TBL[r][21:15]);
            #1;
            check($sformatf("table row %0d", r), observed(), TBL[r][14:0]);
        end

        // R1: reset while a channel is in service
        @(negedge clk);
        drive(7'b1_11_01_1_0);
        @(negedge clk);
        drive(7'b1_11_00_0_0);
        #1;
        check("R1 precondition ch0 in service", observed(), 15'b0_0_0_00000000_00_0_0);
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        check("R1 reset clears service, ieo high", observed(), 15'b0_1_0_00000000_00_0_0);
        drive(7'b0_11_00_0_0);
        #1;
        check("R1 ieo follows iei low", observed(), 15'b0_0_0_00000000_00_0_0);
        rst_n = 1'b1;
        drive(7'b1_11_01_0_0);
        @(negedge clk);
        #1;
        check("R1 request visible after reset", observed(), 15'b1_0_0_00000000_00_0_0);

        // R5: ch1 in service, ch1 request again, ack blocked, state kept
        drive(7'b1_11_10_1_0);
        #1;
        check("R4 ch1 claims lone request", observed(), 15'b1_0_1_10110100_10_0_0);
        @(negedge clk);
        drive(7'b1_10_11_1_0);
        #1;
        check("R5 blocked by in-service ch1", observed(), 15'b0_0_0_00000000_00_0_0);
        @(negedge clk);
        drive(7'b1_11_00_0_1);
        #1;
        check("R7 ch1 still in service, no forward", observed(), 15'b0_0_0_00000000_00_0_0);
        @(negedge clk);
        drive(7'b1_11_00_0_0);
        #1;
        check("R10 idle outputs after release", observed(), 15'b0_1_0_00000000_00_0_0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule